// File: doc/BRIEF.md
# Vector Destination Policy Merger

This block forms the value that one vector instruction leaves in one destination register. It receives the freshly computed result, the register's previous contents, the active vector length, the mask register, the element-width code, the register-grouping code, an optional segment data-width code, the index of the register inside its group, the tail and mask policy bits, and an operation class. For every destination bit it picks one of three sources: the new result, the old contents, or a logic one. It also reports whether the register file should be written at all.

An element counts as tail when it lies at or beyond the vector length, or in the unused part of a register that is only fractionally occupied. An element counts as inactive when it lies inside the body and its mask bit is clear. Agnostic handling is made deterministic: every agnostic element is filled with ones. Each operation class changes these rules. Mask-producing operations work on single bits. Reductions have a body of exactly one element. Always-unmasked operations never have inactive elements. Stores never write the register.

The merge is combinational. Its result is captured into an output register on a valid input strobe and appears one clock later together with a valid flag.

Top module: `vec_policy_merge`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_data` and `out_we` keep their previous values. Synchronous reset clears `out_valid`, `out_we` and `out_data` to zero.
- R2: For class 0 (element op), the element at position j of the register has overall index i = reg_index*EPR + j, where EPR = VLEN/width. Element i takes the new result when i < vl and it is active. An element is active when `mask_en` is 0, or when bit i of `mask` is 1.
- R3: A tail element (index i >= vl) is filled with ones when `tail_agn` = 1 and keeps its old value when `tail_agn` = 0.
- R4: An inactive body element is filled with ones when `mask_agn` = 1 and keeps its old value when `mask_agn` = 0.
- R5: `sew` codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. The element at position j occupies bits [j*width +: width]. The mask bit for element i is always `mask[i]`, whatever the width.
- R6: `lmul` is a signed log2 of the grouping. Codes 0 to 3 give groups of 1, 2, 4 and 8 registers, and `reg_index` then selects the register within the group. Codes 7, 6 and 5 give 1/2, 1/4 and 1/8. With a fractional grouping, `reg_index` is ignored, and positions j >= EPR/2, EPR/4 or EPR/8 respectively are tail regardless of vl.
- R7: When `seg_en` = 1 for class 0 or 3, the element width is taken from `eew` instead of `sew`. The effective grouping log2 is then lmul + eew - sew, and a negative result makes the leftover register space tail as in R6.
- R8: For class 1 (mask-producing), each bit b is one element. Bit b is tail when b >= vl. It is inactive when `mask_en` = 1 and `mask[b]` = 0. `sew`, `lmul`, `seg_en` and `reg_index` have no effect.
- R9: For class 2 (reduction), element 0 at width `sew` takes the new result. All other elements are tail. `mask_en`, `mask` and `mask_agn` have no effect.
- R10: For class 3 (always-unmasked), no element is inactive. `mask_en`, `mask` and `mask_agn` have no effect, and every body element takes the new result.
- R11: For class 4 (store), `out_we` is 0 and `out_data` equals the old register contents.
- R12: For classes 0 to 3, `out_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; captures one merge |
| new_data | input | VLEN | Freshly computed result for this register |
| old_data | input | VLEN | Previous register contents |
| mask | input | VLEN | Mask register, bit i for element i |
| vl | input | $clog2(VLEN)+1 | Vector length in elements |
| sew | input | 2 | Element width code (8/16/32/64) |
| eew | input | 2 | Segment data-width code |
| lmul | input | 3 | Signed log2 grouping code |
| seg_en | input | 1 | Segment access; use eew for layout |
| reg_index | input | 3 | Register position within its group |
| op_class | input | 3 | 0 element, 1 mask-producing, 2 reduction, 3 unmasked, 4 store |
| mask_en | input | 1 | Instruction is masked |
| tail_agn | input | 1 | Tail policy agnostic (fill ones) |
| mask_agn | input | 1 | Mask policy agnostic (fill ones) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | VLEN | Merged register value |
| out_we | output | 1 | Register write enable |

## Verification
The assertions assume that the effective grouping log2 lies between -3 and 3. They also assume that `reg_index` stays below the group size and that no fractional grouping leaves fewer than one element in the register. The unused class codes 5 to 7 are assumed never to appear. The random stimulus picks a width code and a grouping code, computes the effective grouping, and redraws until all of these hold. It then chooses `reg_index` only from the registers the group actually has. The directed cases stay inside the same legal set while they reach the boundaries: vl of zero, vl just inside and just past a register, and each fractional shift.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    typedef enum logic [2:0] {
        OPC_ELEM    = 3'd0,
        OPC_MASKDST = 3'd1,
        OPC_REDUCE  = 3'd2,
        OPC_NOMASK  = 3'd3,
        OPC_STORE   = 3'd4
    } op_class_e;

    // Decoded control that steers the merge datapath.
    typedef struct packed {
        logic [1:0] wcode;       // width code used for element layout
        logic       frac;        // register only partly occupied
        logic [1:0] frac_shift;  // log2 of the fraction divisor
        logic       use_ridx;    // group spans several registers
        logic       mask_dst;    // bit-per-element destination
        logic       reduce;      // single-element body
        logic       mask_apply;  // mask bits create inactive elements
        logic       keep_all;    // destination left untouched
        logic       wen;         // register write enable
    } vpm_ctrl_t;

    function automatic logic signed [4:0] lmul_log(input logic [2:0] code);
        return signed'({code[2], code[2], code});
    endfunction

    function automatic logic signed [4:0] wlog_diff(input logic [1:0] a, input logic [1:0] b);
        return signed'({3'b000, a}) - signed'({3'b000, b});
    endfunction

endpackage

// File: rtl/vpm_decode.sv
module vpm_decode
    import vpm_pkg::*;
(
    input  logic [1:0] sew,
    input  logic [1:0] eew,
    input  logic [2:0] lmul,
    input  logic       seg_en,
    input  logic [2:0] op_class,
    input  logic       mask_en,
    output vpm_ctrl_t  ctrl
);

    op_class_e           opc;
    logic                elem_like;
    logic                seg_act;
    logic signed [4:0]   emul_log;
    logic signed [4:0]   emul_neg;

    assign opc = op_class_e'(op_class);

    always_comb begin
        elem_like = (opc == OPC_ELEM) || (opc == OPC_NOMASK);
        seg_act   = seg_en && elem_like;
        emul_log  = lmul_log(lmul) + (seg_act ? wlog_diff(eew, sew) : 5'sd0);
        emul_neg  = -emul_log;

        ctrl            = '0;
        ctrl.wcode      = seg_act ? eew : sew;
        ctrl.frac       = (emul_log < 5'sd0);
        if (emul_log < -5'sd3) begin
            ctrl.frac_shift = 2'd3;
        end else if (emul_log < 5'sd0) begin
            ctrl.frac_shift = emul_neg[1:0];
        end else begin
            ctrl.frac_shift = 2'd0;
        end
        ctrl.use_ridx   = (emul_log > 5'sd0);
        ctrl.mask_dst   = (opc == OPC_MASKDST);
        ctrl.reduce     = (opc == OPC_REDUCE);
        ctrl.mask_apply = mask_en && ((opc == OPC_ELEM) || (opc == OPC_MASKDST));
        ctrl.keep_all   = (opc == OPC_STORE);
        ctrl.wen        = (opc != OPC_STORE);
    end

endmodule

// File: rtl/vpm_lane.sv
// Classifies every element of one fixed width as tail or inactive and
// expands the result to bit granularity.
module vpm_lane #(
    parameter  int VLEN = 128,
    parameter  int EW   = 8,
    localparam int IW   = $clog2(VLEN)
) (
    input  logic [IW:0]     vl,
    input  logic [VLEN-1:0] mask,
    input  logic [2:0]      reg_index,
    input  logic            use_ridx,
    input  logic            frac,
    input  logic [1:0]      frac_shift,
    input  logic            reduce,
    input  logic            mask_apply,
    output logic [VLEN-1:0] tail_bits,
    output logic [VLEN-1:0] inact_bits
);

    localparam int          EPR   = VLEN / EW;
    localparam logic [IW:0] EPR_V = (IW+1)'(EPR);

    logic [IW:0] base;
    logic [IW:0] cap;

    assign base = use_ridx ? ((IW+1)'(reg_index) * EPR_V) : '0;
    assign cap  = frac ? (EPR_V >> frac_shift) : EPR_V;

    for (genvar j = 0; j < EPR; j++) begin : g_el
        localparam logic [IW:0] JV   = (IW+1)'(j);
        localparam logic        NOT0 = (j != 0);
        logic [IW:0] idx;
        logic        is_tail;
        logic        is_inact;

        assign idx      = base + JV;
        assign is_tail  = reduce ? NOT0 : ((JV >= cap) || (idx >= vl));
        assign is_inact = !reduce && mask_apply && !mask[idx[IW-1:0]];

        assign tail_bits[j*EW +: EW]  = {EW{is_tail}};
        assign inact_bits[j*EW +: EW] = {EW{is_inact}};
    end

endmodule

// File: rtl/vpm_maskbits.sv
// Bit-per-element classification for mask-producing operations.
module vpm_maskbits #(
    parameter  int VLEN = 128,
    localparam int IW   = $clog2(VLEN)
) (
    input  logic [IW:0]     vl,
    input  logic [VLEN-1:0] mask,
    input  logic            mask_apply,
    output logic [VLEN-1:0] tail_bits,
    output logic [VLEN-1:0] inact_bits
);

    for (genvar b = 0; b < VLEN; b++) begin : g_bit
        localparam logic [IW:0] BV = (IW+1)'(b);
        assign tail_bits[b]  = (BV >= vl);
        assign inact_bits[b] = mask_apply && !mask[b];
    end

endmodule

// File: rtl/vpm_combine.sv
// Chooses new data, old data or ones for every bit.
module vpm_combine #(
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] tail_bits,
    input  logic [VLEN-1:0] inact_bits,
    input  logic [VLEN-1:0] new_data,
    input  logic [VLEN-1:0] old_data,
    input  logic            tail_agn,
    input  logic            mask_agn,
    input  logic            keep_all,
    output logic [VLEN-1:0] result
);

    logic [VLEN-1:0] keep;
    logic [VLEN-1:0] fill;
    logic [VLEN-1:0] body_inact;

    always_comb begin
        body_inact = ~tail_bits & inact_bits;
        fill = (tail_bits & {VLEN{tail_agn}}) | (body_inact & {VLEN{mask_agn}});
        keep = {VLEN{keep_all}}
             | (tail_bits & {VLEN{!tail_agn}})
             | (body_inact & {VLEN{!mask_agn}});
        result = (old_data & keep) | (~keep & fill) | (~keep & ~fill & new_data);
    end

endmodule

// File: rtl/vec_policy_merge.sv
module vec_policy_merge
    import vpm_pkg::*;
#(
    parameter  int VLEN = 128,
    localparam int IW   = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VLEN-1:0] new_data,
    input  logic [VLEN-1:0] old_data,
    input  logic [VLEN-1:0] mask,
    input  logic [IW:0]     vl,
    input  logic [1:0]      sew,
    input  logic [1:0]      eew,
    input  logic [2:0]      lmul,
    input  logic            seg_en,
    input  logic [2:0]      reg_index,
    input  logic [2:0]      op_class,
    input  logic            mask_en,
    input  logic            tail_agn,
    input  logic            mask_agn,
    output logic            out_valid,
    output logic [VLEN-1:0] out_data,
    output logic            out_we
);

    localparam int NW = 4;  // one lane per width code

    vpm_ctrl_t       ctrl;
    logic [VLEN-1:0] lane_tail  [NW];
    logic [VLEN-1:0] lane_inact [NW];
    logic [VLEN-1:0] mb_tail;
    logic [VLEN-1:0] mb_inact;
    logic [VLEN-1:0] sel_tail;
    logic [VLEN-1:0] sel_inact;
    logic [VLEN-1:0] merged;

    vpm_decode u_decode (
        .sew      (sew),
        .eew      (eew),
        .lmul     (lmul),
        .seg_en   (seg_en),
        .op_class (op_class),
        .mask_en  (mask_en),
        .ctrl     (ctrl)
    );

    for (genvar k = 0; k < NW; k++) begin : g_lane
        vpm_lane #(.VLEN(VLEN), .EW(8 << k)) u_lane (
            .vl         (vl),
            .mask       (mask),
            .reg_index  (reg_index),
            .use_ridx   (ctrl.use_ridx),
            .frac       (ctrl.frac),
            .frac_shift (ctrl.frac_shift),
            .reduce     (ctrl.reduce),
            .mask_apply (ctrl.mask_apply),
            .tail_bits  (lane_tail[k]),
            .inact_bits (lane_inact[k])
        );
    end

    vpm_maskbits #(.VLEN(VLEN)) u_maskbits (
        .vl         (vl),
        .mask       (mask),
        .mask_apply (ctrl.mask_apply),
        .tail_bits  (mb_tail),
        .inact_bits (mb_inact)
    );

    always_comb begin
        if (ctrl.mask_dst) begin
            sel_tail  = mb_tail;
            sel_inact = mb_inact;
        end else begin
            sel_tail  = lane_tail[ctrl.wcode];
            sel_inact = lane_inact[ctrl.wcode];
        end
    end

    vpm_combine #(.VLEN(VLEN)) u_combine (
        .tail_bits  (sel_tail),
        .inact_bits (sel_inact),
        .new_data   (new_data),
        .old_data   (old_data),
        .tail_agn   (tail_agn),
        .mask_agn   (mask_agn),
        .keep_all   (ctrl.keep_all),
        .result     (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= merged;
                out_we   <= ctrl.wen;
            end
        end
    end

endmodule

// File: rtl/vpm_chk.sv
module vpm_chk #(
    parameter  int VLEN = 128,
    localparam int IW   = $clog2(VLEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [VLEN-1:0] new_data,
    input logic [VLEN-1:0] old_data,
    input logic [IW:0]     vl,
    input logic [1:0]      sew,
    input logic [2:0]      op_class,
    input logic            tail_agn,
    input logic            out_valid,
    input logic [VLEN-1:0] out_data,
    input logic            out_we
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_we)));  // R1
    AST_TAIL_UNDIST_VL0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_class == 3'd0 || op_class == 3'd3) && vl == '0 && !tail_agn)
        |=> out_data == $past(old_data));  // R3
    AST_MASKDST_VL0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd1 && vl == '0 && !tail_agn)
        |=> out_data == $past(old_data));  // R8
    AST_RED_ELEM0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd2 && sew == 2'd0)
        |=> out_data[7:0] == $past(new_data[7:0]));  // R9
    AST_RED_TAIL_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd2 && sew == 2'd0 && tail_agn)
        |=> out_data[VLEN-1:8] == '1);  // R9
    AST_STORE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd4) |=> !out_we);  // R11
    AST_STORE_OLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd4) |=> out_data == $past(old_data));  // R11
    AST_WE_REG_OPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class < 3'd4) |=> out_we);  // R12

endmodule

bind vec_policy_merge vpm_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .new_data  (new_data),
    .old_data  (old_data),
    .vl        (vl),
    .sew       (sew),
    .op_class  (op_class),
    .tail_agn  (tail_agn),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_we    (out_we)
);

// File: tb/tb_vec_policy_merge.sv
`timescale 1ns/1ps
module tb_vec_policy_merge;

    localparam int VLEN = 128;
    localparam int IW   = $clog2(VLEN);

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [VLEN-1:0] new_data, old_data, mask;
    logic [IW:0]     vl;
    logic [1:0]      sew, eew;
    logic [2:0]      lmul, reg_index, op_class;
    logic            seg_en, mask_en, tail_agn, mask_agn;
    logic            out_valid, out_we;
    logic [VLEN-1:0] out_data;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";
    logic            exp_v, exp_we;
    logic [VLEN-1:0] exp_d;

    always #2.5 clk = ~clk;

    vec_policy_merge #(.VLEN(VLEN)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .new_data(new_data),
        .old_data(old_data), .mask(mask), .vl(vl), .sew(sew), .eew(eew),
        .lmul(lmul), .seg_en(seg_en), .reg_index(reg_index), .op_class(op_class),
        .mask_en(mask_en), .tail_agn(tail_agn), .mask_agn(mask_agn),
        .out_valid(out_valid), .out_data(out_data), .out_we(out_we)
    );

    // Behavioural reference: returns {write enable, data}.
    function automatic logic [VLEN:0] ref_model(
        input logic [VLEN-1:0] nd, input logic [VLEN-1:0] od, input logic [VLEN-1:0] mk,
        input int vl_i, input int sew_i, input int eew_i, input int lmul_i,
        input int seg_i, input int ridx, input int opc, input int men,
        input int ta_i, input int ma_i);
        logic [VLEN-1:0] r;
        int w, epr, el, cap, j, i;
        bit tl, ina;
        if (opc == 4) return {1'b0, od};
        for (int b = 0; b < VLEN; b++) begin
            if (opc == 1) begin
                tl  = (b >= vl_i);
                ina = (men != 0) && !mk[b];
            end else if (opc == 2) begin
                w   = 8 << sew_i;
                tl  = (b / w) != 0;
                ina = 0;
            end else begin
                el = (lmul_i >= 4) ? lmul_i - 8 : lmul_i;
                w  = 8 << sew_i;
                if (seg_i != 0) begin
                    el = el + eew_i - sew_i;
                    w  = 8 << eew_i;
                end
                epr = VLEN / w;
                j   = b / w;
                cap = (el < 0) ? (epr >> (-el)) : epr;
                i   = ((el > 0) ? ridx * epr : 0) + j;
                tl  = (j >= cap) || (i >= vl_i);
                ina = (opc == 0) && (men != 0) && !mk[i];
            end
            if (tl)       r[b] = (ta_i != 0) ? 1'b1 : od[b];
            else if (ina) r[b] = (ma_i != 0) ? 1'b1 : od[b];
            else          r[b] = nd[b];
        end
        return {1'b1, r};
    endfunction

    // Expected output register, updated alongside the design.
    always @(posedge clk) begin
        logic [VLEN:0] m;
        if (rst) begin
            exp_v  <= 1'b0;
            exp_we <= 1'b0;
            exp_d  <= '0;
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                m = ref_model(new_data, old_data, mask, int'(vl), int'(sew), int'(eew),
                              int'(lmul), int'(seg_en), int'(reg_index), int'(op_class),
                              int'(mask_en), int'(tail_agn), int'(mask_agn));
                exp_we  <= m[VLEN];
                exp_d   <= m[VLEN-1:0];
                exp_tag <= cur_tag;
            end else begin
                exp_tag <= "R1";
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (out_valid !== exp_v || out_we !== exp_we || out_data !== exp_d) begin
                errors++;
                $display("FAIL %s: valid=%b we=%b data=%h expected valid=%b we=%b data=%h",
                         exp_tag, out_valid, out_we, out_data, exp_v, exp_we, exp_d);
            end
        end
    end

    function automatic logic [VLEN-1:0] rvec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN; k += 32) v[k +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input string tag, input logic [VLEN-1:0] nd, input logic [VLEN-1:0] od,
                        input logic [VLEN-1:0] mk, input int vl_i, input int sew_i,
                        input int eew_i, input int lmul_i, input int seg_i, input int ridx,
                        input int opc, input int men, input int ta_i, input int ma_i);
        @(negedge clk);
        cur_tag   = tag;
        new_data  = nd;
        old_data  = od;
        mask      = mk;
        vl        = (IW+1)'(vl_i);
        sew       = 2'(sew_i);
        eew       = 2'(eew_i);
        lmul      = 3'(lmul_i);
        seg_en    = 1'(seg_i);
        reg_index = 3'(ridx);
        op_class  = 3'(opc);
        mask_en   = 1'(men);
        tail_agn  = 1'(ta_i);
        mask_agn  = 1'(ma_i);
        in_valid  = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic rnd_one();
        int s, e2, lm, el, sg, op, ew, ridx, vli;
        do begin
            s  = $urandom % 4;
            lm = $urandom % 7;
            if (lm >= 4) lm++;
            op = $urandom % 5;
            sg = ((op == 0 || op == 3) && ($urandom % 4 == 0)) ? 1 : 0;
            e2 = $urandom % 4;
            el = ((lm >= 4) ? lm - 8 : lm) + ((sg != 0) ? e2 - s : 0);
            ew = (sg != 0) ? e2 : s;
        end while (el < -3 || el > 3 || el < ew - 3);
        ridx = (el > 0) ? ($urandom % (1 << el)) : 0;
        vli  = ($urandom % 2 == 0) ? ($urandom % 21) : ($urandom % (VLEN + 1));
        send("random", rvec(), rvec(), rvec(), vli, s, e2, lm, sg, ridx, op,
             $urandom % 2, $urandom % 2, $urandom % 2);
    endtask

    initial begin
        logic [VLEN-1:0] nd, od, alt, ones;
        nd   = {(VLEN/32){32'hA5C3_5A3C}};
        od   = {(VLEN/32){32'h1234_8765}};
        alt  = {(VLEN/2){2'b01}};
        ones = '1;
        rst = 1'b1; in_valid = 1'b0; new_data = '0; old_data = '0; mask = '0;
        vl = '0; sew = '0; eew = '0; lmul = '0; seg_en = 0; reg_index = '0;
        op_class = '0; mask_en = 0; tail_agn = 0; mask_agn = 0;
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if (out_valid !== 1'b0 || out_we !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: reset valid=%b we=%b data=%h expected 0 0 0",
                     out_valid, out_we, out_data);
        end
        rst = 1'b0;
        idle(2);

        // R2 full body, all active
        send("R2", nd, od, ones, 16, 0, 0, 0, 0, 0, 0, 1, 1, 1); idle(1);
        // R3 tail at vl=5, agnostic and undisturbed
        send("R3", nd, od, ones, 5, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        send("R3", nd, od, ones, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        send("R3", nd, od, ones, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); idle(1);
        // R4 alternating mask
        send("R4", nd, od, alt, 16, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        send("R4", nd, od, alt, 16, 0, 0, 0, 0, 0, 0, 1, 0, 0); idle(1);
        // R5 each width, mask bit i per element
        send("R5", nd, od, alt, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0);
        send("R5", nd, od, alt, 3, 2, 0, 0, 0, 0, 0, 1, 0, 1);
        send("R5", nd, od, alt, 1, 3, 0, 0, 0, 0, 0, 1, 1, 1); idle(1);
        // R6 fractional and grouped
        send("R6", nd, od, ones, 16, 0, 0, 7, 0, 0, 0, 0, 1, 0);
        send("R6", nd, od, ones, 16, 0, 0, 5, 0, 0, 0, 0, 1, 0);
        send("R6", nd, od, alt, 20, 0, 0, 1, 0, 1, 0, 1, 1, 0);
        send("R6", nd, od, ones, 60, 1, 0, 3, 0, 7, 0, 0, 0, 0); idle(1);
        // R7 segment with narrower data width
        send("R7", nd, od, ones, 16, 2, 0, 0, 1, 0, 0, 0, 1, 0);
        send("R7", nd, od, alt, 9, 0, 1, 0, 1, 0, 3, 1, 1, 1); idle(1);
        // R8 mask-producing class
        send("R8", nd, od, alt, 37, 3, 0, 2, 0, 3, 1, 1, 1, 0);
        send("R8", nd, od, alt, 37, 0, 0, 0, 0, 0, 1, 1, 0, 1);
        send("R8", nd, od, alt, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); idle(1);
        // R9 reduction
        send("R9", nd, od, '0, 4, 2, 0, 1, 0, 0, 2, 1, 1, 1);
        send("R9", nd, od, '0, 4, 0, 0, 0, 0, 0, 2, 1, 0, 1); idle(1);
        // R10 always-unmasked ignores mask
        send("R10", nd, od, '0, 16, 0, 0, 0, 0, 0, 3, 1, 0, 1);
        send("R10", nd, od, '0, 7, 1, 0, 0, 0, 0, 3, 1, 1, 1); idle(1);
        // R11 store
        send("R11", nd, od, alt, 16, 0, 0, 0, 0, 0, 4, 1, 1, 1); idle(2);
        // R12 write enable after a store
        send("R12", nd, od, ones, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0); idle(3);

        for (int n = 0; n < 600; n++) begin
            rnd_one();
            if ($urandom % 5 == 0) idle(1);
        end
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule